// File: doc/BRIEF.md
# SPI Control-Read Register Target

This block is an SPI target that answers register read commands from an SPI host. The host pulls chip-select low and shifts in a 32-bit control header. The header gives the command type, a map selector, a 16-bit start address and a register count. While the header arrives, the target drives a lead word of zeros. It then returns the header unchanged as an echo word, followed by one 32-bit word for each requested register. Each word is sent most significant bit first, and the address steps up by one after every returned word.

The registers sit in a small read-only bank whose values come from a parameter. Any address outside the bank, and any map selector other than the bank's own, reads as zero. Once the header is complete, the target ignores whatever the host keeps shifting in. Raising chip-select ends the command at any point. The SPI pins are taken as synchronous to the system clock, which oversamples the serial clock.

Top module: `ctl_read_target`

## Requirements
- R1: While `rst` is high, or from the first clock edge at which `spi_cs_n` is high, `spi_miso` is 0.
- R2: SPI mode 0 is used. While selected, `spi_miso` changes only on the clock edge at which a falling `spi_sclk` is first seen. Input bits are taken on rising `spi_sclk`. `spi_sclk` must stay high and low for at least 2 clock cycles each.
- R3: The first 32 bits driven after `spi_cs_n` falls are all zero.
- R4: The header is a control read when bit 31 (data flag) is 0 and bit 29 (write flag) is 0. For such a header, bits 32 to 63 of the reply are an exact copy of it, MSB first.
- R5: Header bits 7:1 hold the register count minus one, so one command returns 1 to 128 words. The words follow the echo MSB first. The first word comes from the start address in bits 23:8.
- R6: The address increments by one after each returned word and wraps from 0xFFFF to 0x0000.
- R7: A word returns zero if the map selector in bits 27:24 differs from `MAP_SEL`, or if the address is `NUM_REGS` or higher.
- R8: Host data shifted in after the 32nd header bit has no effect on the reply.
- R9: Once the requested count has been sent, the target drives zeros until `spi_cs_n` rises.
- R10: A rise of `spi_cs_n` at any bit aborts the command. The next frame is decoded from a fresh header.
- R11: If the header is not a control read, every bit after the lead word is zero, including the echo slot.
- R12: Register i of the bank returns `REG_INIT[32*i+31:32*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_cs_n | input | 1 | Active-low chip-select framing a command |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Registered serial data to host |

## Verification
The bench goes after the edges of the reply stream. A 128-word read checks that a seven-bit length field widens to the full count; a design that truncated it would stop after the wrong number of words. A read starting at 0xFFFF checks the address wrap, and reads that run past the bank or use a foreign map selector check that unmapped words are zero and not aliased onto low registers. A write header, a data header and an abort in the middle of the echo check that nothing stale leaks out: a design that echoed every header, or that kept its bit counter across chip-select, would shift out wrong bits in the echo or the next frame. Random host data after the header checks that trailing input cannot corrupt the latched header.

// File: rtl/ctl_rd_pkg.sv
package ctl_rd_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 16;
  localparam int MMS_W  = 4;
  localparam int CNT_W  = 8;   // holds 1..128

  typedef enum logic [1:0] {PH_LEAD, PH_ECHO, PH_DATA} phase_t;

  typedef struct packed {
    logic              is_rd;
    logic [MMS_W-1:0]  mms;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  count;
  } rd_cmd_t;

  // Field positions: 31 data flag, 29 write flag, 27:24 map, 23:8 address, 7:1 count-1
  function automatic rd_cmd_t decode_hdr(input logic [WORD_W-1:0] h);
    rd_cmd_t r;
    r.is_rd = !h[31] && !h[29];
    r.mms   = h[27:24];
    r.addr  = h[23:8];
    r.count = {1'b0, h[7:1]} + 8'd1;
    return r;
  endfunction
endpackage

// File: rtl/ctl_spi_edge.sv
module ctl_spi_edge (
  input  logic clk,
  input  logic sclk,
  input  logic cs_n,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q & ~cs_n;
  assign fall = ~sclk & sclk_q & ~cs_n;
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int MMS_W    = 4,
  parameter logic [MMS_W-1:0] MAP_SEL = '0,
  parameter logic [NUM_REGS*WORD_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MMS_W-1:0]  mms,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  logic [WORD_W-1:0] mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    assign mem[i] = INIT[i*WORD_W +: WORD_W];
  end

  logic hit;
  assign hit = (mms == MAP_SEL) && (addr < LIMIT);

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (hit) rd_data <= mem[addr[IDX_W-1:0]];
    else          rd_data <= '0;
  end
endmodule

// File: rtl/ctl_rd_seq.sv
module ctl_rd_seq
  import ctl_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              mosi,
  input  logic [WORD_W-1:0] rd_data,
  output logic [MMS_W-1:0]  rd_mms,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              miso
);
  localparam logic [4:0] LAST_BIT = 5'd31;

  phase_t            phase_q;
  logic [4:0]        bit_q;
  logic [30:0]       sh_q;
  logic [WORD_W-1:0] hdr_q;
  logic              is_rd_q;
  logic [MMS_W-1:0]  mms_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [WORD_W-1:0] tx_q;
  logic              miso_q;

  rd_cmd_t           cmd_d;
  logic [WORD_W-1:0] nxt_word;
  logic              take_data;

  assign cmd_d     = decode_hdr({sh_q, mosi});
  assign take_data = (phase_q == PH_DATA) && is_rd_q && (rem_q != '0);

  always_comb begin
    nxt_word = '0;
    if (phase_q == PH_ECHO && is_rd_q) nxt_word = hdr_q;
    else if (take_data)                nxt_word = rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      phase_q <= PH_LEAD;
      bit_q   <= '0;
      sh_q    <= '0;
      hdr_q   <= '0;
      is_rd_q <= 1'b0;
      mms_q   <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      tx_q    <= '0;
      miso_q  <= 1'b0;
    end else begin
      if (rise) begin
        bit_q <= bit_q + 5'd1;
        if (bit_q == LAST_BIT) begin
          case (phase_q)
            PH_LEAD: phase_q <= PH_ECHO;
            default: phase_q <= PH_DATA;
          endcase
        end
        if (phase_q == PH_LEAD) begin
          if (bit_q == LAST_BIT) begin
            hdr_q   <= {sh_q, mosi};
            is_rd_q <= cmd_d.is_rd;
            mms_q   <= cmd_d.mms;
            addr_q  <= cmd_d.addr;
            rem_q   <= cmd_d.is_rd ? cmd_d.count : '0;
          end else begin
            sh_q <= {sh_q[29:0], mosi};
          end
        end
      end
      if (fall) begin
        if (bit_q == '0) begin
          miso_q <= nxt_word[WORD_W-1];
          tx_q   <= {nxt_word[WORD_W-2:0], 1'b0};
          if (take_data) begin
            rem_q  <= rem_q - 1'b1;
            addr_q <= addr_q + 1'b1;
          end
        end else begin
          miso_q <= tx_q[WORD_W-1];
          tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rd_mms  = mms_q;
  assign rd_addr = addr_q;
  assign miso    = miso_q;
endmodule

// File: rtl/ctl_read_target.sv
module ctl_read_target
  import ctl_rd_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [MMS_W-1:0] MAP_SEL = '0,
  parameter logic [NUM_REGS*WORD_W-1:0] REG_INIT = {
    32'h7777_0007, 32'h6666_0006, 32'h5555_0005, 32'h4444_0004,
    32'h3333_0003, 32'h2222_0002, 32'h1111_0001, 32'hA5A5_0000}
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic              rise, fall;
  logic [MMS_W-1:0]  rd_mms;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;

  ctl_spi_edge u_edge (
    .clk  (clk),
    .sclk (spi_sclk),
    .cs_n (spi_cs_n),
    .rise (rise),
    .fall (fall)
  );

  ctl_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W),
    .MMS_W    (MMS_W),
    .MAP_SEL  (MAP_SEL),
    .INIT     (REG_INIT)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .mms     (rd_mms),
    .addr    (rd_addr),
    .rd_data (rd_data)
  );

  ctl_rd_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (spi_cs_n),
    .rise    (rise),
    .fall    (fall),
    .mosi    (spi_mosi),
    .rd_data (rd_data),
    .rd_mms  (rd_mms),
    .rd_addr (rd_addr),
    .miso    (spi_miso)
  );
endmodule

// File: rtl/ctl_read_target_chk.sv
module ctl_read_target_chk (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic cs_n,
  input logic miso
);
  logic       sclk_q;
  logic [5:0] seen_q;

  always_ff @(posedge clk) begin
    sclk_q <= sclk;
    if (rst || cs_n)                              seen_q <= '0;
    else if (sclk && !sclk_q && seen_q < 6'd32)   seen_q <= seen_q + 6'd1;
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !miso);

  // R2
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !(sclk_q && !sclk)) |=> $stable(miso));

  // R3
  lead_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && seen_q < 6'd32) |-> !miso);

  // R10
  frame_start_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !miso);
endmodule

bind ctl_read_target ctl_read_target_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .sclk (spi_sclk),
  .cs_n (spi_cs_n),
  .miso (spi_miso)
);

// File: tb/ctl_read_target_tb.sv
`timescale 1ns/1ps
module ctl_read_target_tb_top;
  localparam logic [255:0] INIT = {
    32'hDEAD_0007, 32'hC0DE_0006, 32'hBEEF_0005, 32'h1234_0004,
    32'h0F0F_0003, 32'h8000_0002, 32'h0000_0001, 32'hFFFF_FFFF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int n_chk = 0;
  int n_fail = 0;
  logic prev_cs = 1'b1;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  ctl_read_target #(.NUM_REGS(8), .MAP_SEL(4'h0), .REG_INIT(INIT)) dut_i (
    .clk (clk), .rst (rst), .spi_sclk (sclk),
    .spi_cs_n (cs_n), .spi_mosi (mosi), .spi_miso (miso)
  );

  task automatic check(input logic act, input logic exp, input string req, input int idx);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: miso actual %0b expected %0b (bit %0d)", req, act, exp, idx);
    end
  endtask

  // R1: every clock, a deselected target drives zero
  always @(negedge clk) begin
    if (!rst && cs_n && prev_cs && !done) check(miso, 1'b0, "R1", -1);
    prev_cs <= cs_n;
  end

  function automatic logic [31:0] reg_model(input logic [3:0] mms, input logic [15:0] a);
    if (mms == 4'h0 && a < 16'd8) return INIT[a*32 +: 32];
    return 32'h0;
  endfunction

  function automatic logic [31:0] mk_hdr(input logic [3:0] mms, input logic [15:0] a, input int cnt);
    logic [6:0] l = 7'(cnt - 1);
    return {4'b0000, mms, a, l, 1'b0};
  endfunction

  // Drives one frame of `words` words; stops after abort_bit bits when abort_bit >= 0
  task automatic run_frame(input logic [31:0] hdr, input int words, input int abort_bit, input bit noisy);
    logic  exp_q[$];
    string tag_q[$];
    logic  is_rd = !hdr[31] && !hdr[29];
    int    cnt = int'(hdr[7:1]) + 1;
    int    nbits;
    for (int b = 31; b >= 0; b--) begin exp_q.push_back(1'b0); tag_q.push_back("R3"); end
    for (int b = 31; b >= 0; b--) begin
      exp_q.push_back(is_rd ? hdr[b] : 1'b0);
      tag_q.push_back(is_rd ? "R4" : "R11");
    end
    for (int w = 2; w < words; w++) begin
      int idx = w - 2;
      logic [31:0] v = 32'h0;
      string t;
      if (is_rd && idx < cnt) begin
        logic [15:0] a = hdr[23:8] + 16'(idx);
        v = reg_model(hdr[27:24], a);
        if (hdr[27:24] != 4'h0 || a >= 16'd8) t = "R7";
        else t = (idx == 0) ? "R5" : "R6";
      end else t = is_rd ? "R9" : "R11";
      for (int b = 31; b >= 0; b--) begin exp_q.push_back(v[b]); tag_q.push_back(t); end
    end
    nbits = (abort_bit >= 0) ? abort_bit : exp_q.size();
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? hdr[31-i] : (noisy ? 1'($urandom) : 1'b0);
      repeat (4) @(negedge clk);
      check(miso, exp_q[i], tag_q[i], i);   // R2: sampled just before the rising edge
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(miso, 1'b0, "R1", -1);            // reset state
    rst = 1'b0;
    repeat (3) @(negedge clk);
    run_frame(mk_hdr(4'h0, 16'h0003, 1), 4, -1, 1'b0);     // R5 single, R9 trailing zeros
    run_frame(mk_hdr(4'h0, 16'h0000, 8), 11, -1, 1'b1);    // R12 full bank, R8 noisy host data
    run_frame(mk_hdr(4'h0, 16'h0006, 4), 6, -1, 1'b1);     // R7 crossing end of bank
    run_frame(mk_hdr(4'h1, 16'h0002, 2), 4, -1, 1'b0);     // R7 foreign map selector
    run_frame(mk_hdr(4'h0, 16'hFFFF, 2), 5, -1, 1'b0);     // R6 address wrap
    run_frame(mk_hdr(4'h0, 16'h0000, 128), 132, -1, 1'b1); // R5 maximum count
    run_frame(mk_hdr(4'h0, 16'h0001, 1) | 32'h2000_0000, 4, -1, 1'b0); // R11 write header
    run_frame(mk_hdr(4'h0, 16'h0001, 1) | 32'h8000_0000, 3, -1, 1'b0); // R11 data header
    run_frame(mk_hdr(4'h0, 16'h0001, 3), 5, 50, 1'b1);     // R10 abort inside echo
    run_frame(mk_hdr(4'h0, 16'h0005, 1), 3, -1, 1'b0);     // R10 fresh frame after abort
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule